// File: doc/BRIEF.md
# Debug reset hold controller

This block produces the internal core reset and the two instruction-cache invalidate strobes (main and mini) for a processor with a JTAG debug port. It combines the external reset pin with a scan-controlled debug path. A compact instruction register, forced to its identification code by TRST, selects a debug control/status shift register. Through that register a host can set a hold-reset latch, which keeps the core in reset after the pin has been released, and a halt bit, which makes the core enter its debug handler when it finally runs.

Two-flop synchronisers bring both reset inputs into the core clock. Core reset is asserted as soon as the pin falls and is released on a clock edge. When reset is entered, the block decides whether to invalidate the caches. A cold reset (pin and TRST together) always invalidates. A warm reset (pin only) invalidates only when neither halt nor cache-load mode is active, so that code a debugger placed in the caches survives.

Two minimum-wait monitors count TCK cycles (clocks qualified by `tck_en`). One counts after each data-register update in cache-load mode and the other counts after the core leaves reset. Each raises a flag once its minimum has been reached.

Top module: `dbg_rst_ctrl`

## Requirements
- R1: While TRST is active the instruction register holds the identification code 5'h01, and halt and hold read 0. An IR capture loads 5'b00001, which shifts out on `tdo` least significant bit first.
- R2: Asserting pin reset and TRST together gives a pulse on both `inv_main` and `inv_mini` in the first clock after the assertion, whatever mode was active before.
- R3: A warm reset (pin only) gives no invalidate pulse if halt is set (control bit 0) or if the instruction register holds the cache-load code 5'h07.
- R4: A warm reset with halt clear and any instruction other than 5'h07 pulses both invalidate strobes in the first clock after the assertion.
- R5: Each invalidate strobe lasts exactly one clock per reset entry.
- R6: With the debug-select code 5'h09 in the instruction register, a DR update copies scanned bit 1 to hold and bit 0 to halt. A DR capture loads halt into bit 0, hold into bit 1 and core-in-reset into bit 2, with the other bits 0. Shifting is least significant bit first.
- R7: A DR update under any other instruction leaves halt and hold unchanged.
- R8: `core_rst_n` falls as the pin falls. With hold clear, it rises on the third clock edge after the pin is released. While hold is set it stays low. It rises on the second edge after the update that clears hold.
- R9: Clearing hold while writing halt as 1 leaves `halt_mode` high after the core leaves reset.
- R10: `upd_gap_ok` is high after TRST, drops on a DR update under code 5'h07, and rises again after 15 further TCK cycles.
- R11: `rel_wait_ok` is low while the core is in reset and rises 2030 TCK cycles after `core_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| trst_n | input | 1 | JTAG TRST, active low, asynchronous |
| tck_en | input | 1 | Marks a clock as one TCK cycle; qualifies every TAP event |
| tdi | input | 1 | Scan data in |
| ir_capture | input | 1 | Decoded TAP event: capture into the instruction register |
| ir_shift | input | 1 | Decoded TAP event: shift the instruction register |
| ir_update | input | 1 | Decoded TAP event: update the instruction register |
| dr_capture | input | 1 | Decoded TAP event: capture into the data register |
| dr_shift | input | 1 | Decoded TAP event: shift the data register |
| dr_update | input | 1 | Decoded TAP event: update the data register |
| tdo | output | 1 | Scan data out |
| core_rst_n | output | 1 | Internal core reset, active low |
| inv_main | output | 1 | One-clock invalidate strobe for the main instruction cache |
| inv_mini | output | 1 | One-clock invalidate strobe for the mini instruction cache |
| halt_mode | output | 1 | Halt bit of the debug control register |
| upd_gap_ok | output | 1 | At least 15 TCK cycles since the last cache-load DR update |
| rel_wait_ok | output | 1 | At least 2030 TCK cycles since the core left reset |

## Verification
The assertions take for granted that each decoded TAP event lasts one clock, that events never overlap one another, and that they only take effect when `tck_en` is high. They also assume each reset pin is held low for at least two clocks, so the synchronisers see it. The stimulus meets these assumptions by driving every input at the falling clock edge through scan tasks. These tasks raise one event at a time in the order capture, shift, update. `tck_en` stays high throughout, so every clock counts as a TCK cycle.

// File: rtl/dbg_rst_pkg.sv
package dbg_rst_pkg;
  localparam int IR_W = 5;
  localparam int DR_W = 8;

  localparam logic [IR_W-1:0] IR_IDCODE = 5'h01;
  localparam logic [IR_W-1:0] IR_DBGSEL = 5'h09;
  localparam logic [IR_W-1:0] IR_LOAD   = 5'h07;
  localparam logic [IR_W-1:0] IR_CAPT   = 5'b00001;

  localparam int HALT_BIT = 0;
  localparam int HOLD_BIT = 1;
  localparam int CRST_BIT = 2;

  // cold resets always invalidate; warm ones only outside debug modes
  function automatic logic inv_wanted(input logic cold, input logic halt,
                                      input logic load);
    return cold | ~(halt | load);
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ff <= '0;
    else         ff <= {ff[STAGES-2:0], 1'b1};
  end

  assign rst_o = ~ff[STAGES-1];
endmodule

// File: rtl/jtag_regs.sv
module jtag_regs
  import dbg_rst_pkg::*;
#(
  parameter int IRW = IR_W,
  parameter int DRW = DR_W
) (
  input  logic clk,
  input  logic trst_rst,
  input  logic tck_en,
  input  logic tdi,
  input  logic ir_capture,
  input  logic ir_shift,
  input  logic ir_update,
  input  logic dr_capture,
  input  logic dr_shift,
  input  logic dr_update,
  input  logic in_rst,
  output logic tdo,
  output logic halt,
  output logic hold,
  output logic load_mode,
  output logic load_upd
);
  logic [IRW-1:0] ir, ir_sr;
  logic [DRW-1:0] dr_sr, cap;
  logic sel_dbg;
  logic ir_cap_ev, ir_sh_ev, ir_upd_ev, dr_cap_ev, dr_sh_ev, dr_upd_ev;

  assign ir_cap_ev = tck_en & ir_capture;
  assign ir_sh_ev  = tck_en & ir_shift;
  assign ir_upd_ev = tck_en & ir_update;
  assign dr_cap_ev = tck_en & dr_capture;
  assign dr_sh_ev  = tck_en & dr_shift;
  assign dr_upd_ev = tck_en & dr_update;

  assign sel_dbg   = (ir == IRW'(IR_DBGSEL));
  assign load_mode = (ir == IRW'(IR_LOAD));
  assign load_upd  = dr_upd_ev & load_mode;

  always_comb begin
    cap = '0;
    cap[HALT_BIT] = halt;
    cap[HOLD_BIT] = hold;
    cap[CRST_BIT] = in_rst;
  end

  always_ff @(posedge clk or posedge trst_rst) begin
    if (trst_rst) begin
      ir    <= IRW'(IR_IDCODE);
      ir_sr <= '0;
    end else begin
      if (ir_cap_ev)     ir_sr <= IRW'(IR_CAPT);
      else if (ir_sh_ev) ir_sr <= {tdi, ir_sr[IRW-1:1]};
      if (ir_upd_ev)     ir <= ir_sr;
    end
  end

  always_ff @(posedge clk or posedge trst_rst) begin
    if (trst_rst) begin
      dr_sr <= '0;
      halt  <= 1'b0;
      hold  <= 1'b0;
    end else if (sel_dbg) begin
      if (dr_cap_ev)     dr_sr <= cap;
      else if (dr_sh_ev) dr_sr <= {tdi, dr_sr[DRW-1:1]};
      if (dr_upd_ev) begin
        halt <= dr_sr[HALT_BIT];
        hold <= dr_sr[HOLD_BIT];
      end
    end
  end

  assign tdo = ir_shift ? ir_sr[0] : ((dr_shift & sel_dbg) ? dr_sr[0] : 1'b0);

  AST_TRST_IDCODE: assert property (@(posedge clk)
    trst_rst |-> (ir == IRW'(IR_IDCODE)) && !halt && !hold); // R1
  AST_HOLD_FROM_SCAN: assert property (@(posedge clk) disable iff (trst_rst)
    (dr_upd_ev && sel_dbg) |=> (hold == $past(dr_sr[HOLD_BIT]))); // R6
  AST_FOREIGN_UPDATE: assert property (@(posedge clk) disable iff (trst_rst)
    (dr_upd_ev && !sel_dbg) |=> $stable(hold) && $stable(halt)); // R7
endmodule

// File: rtl/tck_min_cnt.sv
module tck_min_cnt #(
  parameter int MIN        = 15,
  parameter bit START_DONE = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic restart,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(MIN + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                    cnt <= START_DONE ? LIM : '0;
    else if (restart)            cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (arst)
    (done && !restart) |=> done); // R10
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (arst)
    restart |=> !done); // R10
endmodule

// File: rtl/dbg_rst_ctrl.sv
module dbg_rst_ctrl
  import dbg_rst_pkg::*;
#(
  parameter int GAP_MIN = 15,
  parameter int REL_MIN = 2030
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic trst_n,
  input  logic tck_en,
  input  logic tdi,
  input  logic ir_capture,
  input  logic ir_shift,
  input  logic ir_update,
  input  logic dr_capture,
  input  logic dr_shift,
  input  logic dr_update,
  output logic tdo,
  output logic core_rst_n,
  output logic inv_main,
  output logic inv_mini,
  output logic halt_mode,
  output logic upd_gap_ok,
  output logic rel_wait_ok
);
  logic pin_rst, trst_rst;
  logic halt, hold, load_mode, load_upd;
  logic armed, entry, want;
  logic core_q, inv_main_q, inv_mini_q;

  rst_sync #(.STAGES(2)) u_pin_sync (.clk(clk), .arst_n(rst_pin_n), .rst_o(pin_rst));
  rst_sync #(.STAGES(2)) u_trst_sync (.clk(clk), .arst_n(trst_n), .rst_o(trst_rst));

  jtag_regs #(.IRW(IR_W), .DRW(DR_W)) u_jtag (
    .clk(clk), .trst_rst(trst_rst), .tck_en(tck_en), .tdi(tdi),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .in_rst(~core_q), .tdo(tdo), .halt(halt), .hold(hold),
    .load_mode(load_mode), .load_upd(load_upd)
  );

  // reset entry: first clock in which the synchronised pin reads active
  always_ff @(posedge clk) armed <= ~pin_rst;
  assign entry = armed & pin_rst;
  assign want  = inv_wanted(trst_rst, halt, load_mode);

  always_ff @(posedge clk) begin
    inv_main_q <= entry & want;
    inv_mini_q <= entry & want;
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) core_q <= 1'b0;
    else            core_q <= ~pin_rst & ~hold;
  end

  tck_min_cnt #(.MIN(GAP_MIN), .START_DONE(1'b1)) u_gap (
    .clk(clk), .arst(trst_rst), .restart(load_upd), .tick(tck_en), .done(upd_gap_ok));
  tck_min_cnt #(.MIN(REL_MIN), .START_DONE(1'b0)) u_rel (
    .clk(clk), .arst(~core_q), .restart(1'b0), .tick(tck_en), .done(rel_wait_ok));

  assign core_rst_n = core_q;
  assign inv_main   = inv_main_q;
  assign inv_mini   = inv_mini_q;
  assign halt_mode  = halt;

  AST_COLD_BOTH: assert property (@(posedge clk)
    (entry && trst_rst) |=> (inv_main && inv_mini)); // R2
  AST_WARM_DEBUG_KEEP: assert property (@(posedge clk) disable iff (trst_rst)
    (entry && (halt || load_mode)) |=> (!inv_main && !inv_mini)); // R3
  AST_WARM_NORMAL: assert property (@(posedge clk) disable iff (trst_rst)
    (entry && !halt && !load_mode) |=> (inv_main && inv_mini)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk)
    (inv_main || inv_mini) |=> (!inv_main && !inv_mini)); // R5
  AST_HOLD_KEEPS_RST: assert property (@(posedge clk) disable iff (trst_rst)
    hold |=> !core_rst_n); // R8
  AST_PIN_FORCES_RST: assert property (@(posedge clk)
    !rst_pin_n |-> !core_rst_n); // R8
  AST_REL_AFTER_RUN: assert property (@(posedge clk)
    rel_wait_ok |-> core_rst_n); // R11
endmodule

// File: tb/sim_dbg_rst_ctrl.sv
module sim_dbg_rst_ctrl;
  import dbg_rst_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_pin_n, trst_n, tck_en, tdi;
  logic ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update;
  logic tdo, core_rst_n, inv_main, inv_mini, halt_mode, upd_gap_ok, rel_wait_ok;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // {cold, halt, load, expected main, expected mini}
  localparam logic [4:0] ROWS [0:5] = '{
    5'b000_11, 5'b010_00, 5'b001_00, 5'b011_00, 5'b110_11, 5'b101_11 };

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_rst_ctrl u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .trst_n(trst_n), .tck_en(tck_en), .tdi(tdi),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .tdo(tdo), .core_rst_n(core_rst_n), .inv_main(inv_main), .inv_mini(inv_mini),
    .halt_mode(halt_mode), .upd_gap_ok(upd_gap_ok), .rel_wait_ok(rel_wait_ok));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic scan_ir(input logic [IR_W-1:0] code, output logic [IR_W-1:0] cap);
    ir_capture = 1'b1;
    @(negedge clk);
    ir_capture = 1'b0;
    ir_shift = 1'b1;
    for (int i = 0; i < IR_W; i++) begin
      tdi = code[i];
      #1 cap[i] = tdo;
      @(negedge clk);
    end
    ir_shift = 1'b0;
    ir_update = 1'b1;
    @(negedge clk);
    ir_update = 1'b0;
  endtask

  task automatic scan_dr(input logic [DR_W-1:0] val, output logic [DR_W-1:0] cap);
    dr_capture = 1'b1;
    @(negedge clk);
    dr_capture = 1'b0;
    dr_shift = 1'b1;
    for (int i = 0; i < DR_W; i++) begin
      tdi = val[i];
      #1 cap[i] = tdo;
      @(negedge clk);
    end
    dr_shift = 1'b0;
    dr_update = 1'b1;
    @(negedge clk);
    dr_update = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [IR_W-1:0] icap;
    logic [DR_W-1:0] dcap;
    rst_pin_n = 1'b0; trst_n = 1'b0; tck_en = 1'b1; tdi = 1'b0;
    ir_capture = 1'b0; ir_shift = 1'b0; ir_update = 1'b0;
    dr_capture = 1'b0; dr_shift = 1'b0; dr_update = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 reset core", core_rst_n, 0);
    chk("R1 halt cleared", halt_mode, 0);
    chk("R10 gap flag after TRST", upd_gap_ok, 1);
    chk("R11 wait flag in reset", rel_wait_ok, 0);
    rst_pin_n = 1'b1; trst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 still held at 2nd edge", core_rst_n, 0);
    @(negedge clk);
    chk("R8 released at 3rd edge", core_rst_n, 1);

    scan_ir(IR_DBGSEL, icap);
    chk("R1 IR capture pattern", int'(icap), int'(IR_CAPT));
    scan_dr(8'h01, dcap);
    chk("R6 capture idle status", int'(dcap), 0);
    chk("R6 halt written", halt_mode, 1);
    scan_dr(8'h00, dcap);
    chk("R6 capture halt status", int'(dcap), 1);
    chk("R6 halt cleared", halt_mode, 0);

    for (int r = 0; r < 6; r++) begin
      logic [4:0] row;
      string tag;
      row = ROWS[r];
      tag = row[4] ? "R2 cold" : (row[1] ? "R4 warm normal" : "R3 warm debug");
      trst_n = 1'b0;
      repeat (3) @(negedge clk);
      trst_n = 1'b1;
      repeat (3) @(negedge clk);
      if (row[3]) begin
        scan_ir(IR_DBGSEL, icap);
        scan_dr(8'h01, dcap);
      end
      if (row[2]) scan_ir(IR_LOAD, icap);
      rst_pin_n = 1'b0;
      if (row[4]) trst_n = 1'b0;
      #1 chk("R8 async assert", core_rst_n, 0);
      @(negedge clk);
      chk({tag, " main"}, inv_main, int'(row[1]));
      chk({tag, " mini"}, inv_mini, int'(row[0]));
      @(negedge clk);
      chk("R5 main single", inv_main, 0);
      chk("R5 mini single", inv_mini, 0);
      rst_pin_n = 1'b1; trst_n = 1'b1;
      repeat (4) @(negedge clk);
      if (!row[4] && row[3]) chk("R3 halt kept over warm reset", halt_mode, 1);
    end

    // foreign DR update (R7) and gap monitor (R10)
    trst_n = 1'b0;
    repeat (3) @(negedge clk);
    trst_n = 1'b1;
    repeat (3) @(negedge clk);
    scan_ir(IR_LOAD, icap);
    scan_dr(8'h03, dcap);
    chk("R7 halt untouched", halt_mode, 0);
    chk("R7 core not held", core_rst_n, 1);
    chk("R10 gap cleared by update", upd_gap_ok, 0);
    repeat (14) @(negedge clk);
    chk("R10 gap at 14", upd_gap_ok, 0);
    @(negedge clk);
    chk("R10 gap at 15", upd_gap_ok, 1);

    // hold reset across pin release, then release keeping halt
    rst_pin_n = 1'b0; trst_n = 1'b0;
    repeat (2) @(negedge clk);
    trst_n = 1'b1;
    repeat (4) @(negedge clk);
    scan_ir(IR_DBGSEL, icap);
    scan_dr(8'h03, dcap);
    rst_pin_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 hold keeps reset", core_rst_n, 0);
    chk("R11 no wait flag while held", rel_wait_ok, 0);
    scan_dr(8'h01, dcap);
    chk("R6 capture held status", int'(dcap), 7);
    chk("R8 update edge still held", core_rst_n, 0);
    @(negedge clk);
    chk("R8 release after hold cleared", core_rst_n, 1);
    chk("R9 halt kept across release", halt_mode, 1);
    repeat (REL_CHECK) @(negedge clk);
    chk("R11 wait at 2029", rel_wait_ok, 0);
    @(negedge clk);
    chk("R11 wait at 2030", rel_wait_ok, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam int REL_CHECK = 2029;
endmodule